// File: doc/BRIEF.md
# Oversampling NRZ Bit-Timing Recovery

This block recovers bit timing from an asynchronous NRZ serial line. A local clock at sixteen times the nominal bit rate samples the line. For the nominal 6.9375 Mbit/s stream that clock is 111 MHz. The raw input first passes through a two-flop synchroniser. A two-entry sample history then looks for level changes, and each qualified change zeroes a free-running phase counter. Between changes the counter wraps by itself, so bit timing continues through runs of identical bits.

When the phase counter reaches its mid-bit value, the block raises a one-cycle strobe. On that same cycle it captures the synchronised line level as the recovered bit. A downstream deframer consumes the strobe and bit pair. It sees one strobe per bit period whether or not the bit started with an edge. Because every qualified edge re-centres the counter, the block keeps lock over a broad spread of input rates, roughly seven percent either side of nominal.

Top module: `nrz_bit_timing`

## Requirements
- R1: While `rst_n` is low, `strobe_o`, `bit_o` and `edge_o` are 0. Asserting `rst_n` clears them at once, without waiting for a clock edge.
- R2: A level change on `line_in` that is present at rising edge k+1 and held raises `edge_o` after rising edge k+3. The three edges are two synchroniser flops and one detect register. `edge_o` stays high for exactly one cycle.
- R3: A change qualifies as an edge only if the two previous samples agreed with each other. A pulse one sample wide therefore gives one `edge_o` pulse, for its leading change only. A pulse two samples wide gives two pulses.
- R4: `strobe_o` rises exactly 9 clock cycles after the `edge_o` pulse that re-centred the phase. The phase counter reads 0 on the cycle after the flag, and the strobe is registered when the phase is 7.
- R5: With no edges on the line, the phase counter wraps from 15 to 0, and `strobe_o` pulses exactly every 16 cycles.
- R6: `strobe_o` is never high on two consecutive cycles.
- R7: When `strobe_o` is high, `bit_o` equals the `line_in` level that was sampled three rising edges earlier. `bit_o` does not change on cycles where `strobe_o` is low.
- R8: For bit periods of 15, 16 and 17 clocks, each transmitted bit gets exactly one strobe and is recovered correctly. This holds for runs of up to 3 equal bits off nominal and for runs of 12 equal bits at 16 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Sampling clock at 16x the nominal bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| line_in | input | 1 | Raw asynchronous NRZ data line |
| strobe_o | output | 1 | One-cycle pulse at mid-bit, once per recovered bit |
| bit_o | output | 1 | Recovered data bit, updated with each strobe |
| edge_o | output | 1 | One-cycle flag marking each qualified line transition |

## Verification
An alternating stream at bit periods of 15, 16 and 17 clocks shows whether the edge re-centring keeps one strobe per bit at both ends of the rate range and at nominal. Long runs of equal bits at 16 clocks exercise the free-running wrap without edges. Runs of up to three equal bits at 15 and 17 clocks show whether the drift that builds up between edges stays inside a bit. Isolated one- and two-sample pulses tell the qualification rule apart from a plain change detector. A fixed-phase edge after an idle line pins down the edge-flag and strobe latencies.

// File: rtl/nbt_pkg.sv
`timescale 1ns/1ps
package nbt_pkg;

  // Default oversampling ratio, phase counter width and synchroniser depth.
  localparam int unsigned NBT_OVERSAMPLE  = 16;
  localparam int unsigned NBT_CNT_W       = 5;
  localparam int unsigned NBT_SYNC_STAGES = 2;

  // Phase at which the mid-bit strobe is registered.
  function automatic int unsigned nbt_mid_phase(input int unsigned oversample);
    return oversample / 2 - 1;
  endfunction

endpackage

// File: rtl/nbt_sync_chain.sv
`timescale 1ns/1ps
module nbt_sync_chain #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  assign stage_d[0] = d;
  for (genvar g = 1; g < STAGES; g++) begin : g_chain
    assign stage_d[g] = stage_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/nbt_edge_detect.sv
`timescale 1ns/1ps
module nbt_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic smp,
  output logic edge_o
);

  logic [1:0] hist_q, hist_d;
  logic       flag_q, flag_d;

  // Next state: shift the history and qualify a change against a stable pair.
  always_comb begin
    hist_d = {hist_q[0], smp};
    flag_d = (hist_q[0] == hist_q[1]) && (hist_q[0] != smp);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      flag_q <= 1'b0;
    end else begin
      hist_q <= hist_d;
      flag_q <= flag_d;
    end
  end

  assign edge_o = flag_q;

  // R3: a flagged change leaves the history split, so no flag can follow it.
  p_edge_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q |=> !flag_q);

  // R2: a flag is always preceded by a change of the synchronised sample.
  p_edge_needs_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> (hist_q[0] != hist_q[1]));

endmodule

// File: rtl/nbt_phase_timer.sv
`timescale 1ns/1ps
module nbt_phase_timer #(
  parameter int unsigned OVERSAMPLE = 16,
  parameter int unsigned CNT_W      = 5,
  parameter int unsigned MID_PHASE  = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic realign,
  input  logic smp,
  output logic strobe_o,
  output logic bit_o
);

  localparam logic [CNT_W-1:0] LAST_PH = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] MID_PH  = CNT_W'(MID_PHASE);

  logic [CNT_W-1:0] phase_q, phase_d;
  logic             strobe_q, strobe_d;
  logic             bit_q, bit_d;
  logic             at_mid;
  logic             cap_en;

  assign at_mid = (phase_q == MID_PH);
  assign cap_en = at_mid;

  // Next state: zero on a qualified edge or at the last phase, else count.
  always_comb begin
    if (realign || (phase_q == LAST_PH)) phase_d = '0;
    else                                 phase_d = phase_q + CNT_W'(1);
    strobe_d = at_mid;
    bit_d    = cap_en ? smp : bit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= '0;
      strobe_q <= 1'b0;
      bit_q    <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      strobe_q <= strobe_d;
      bit_q    <= bit_d;
    end
  end

  assign strobe_o = strobe_q;
  assign bit_o    = bit_q;

  // R5: the phase never leaves 0..OVERSAMPLE-1.
  p_phase_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= LAST_PH);

  // R5: after the last phase the counter is back at zero.
  p_phase_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == LAST_PH) |=> (phase_q == '0));

  // R4: a qualified edge zeroes the phase on the next cycle.
  p_realign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    realign |=> (phase_q == '0));

  // R4: the mid phase produces a strobe on the next cycle.
  p_mid_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    at_mid |=> strobe_q);

  // R6: the strobe lasts a single cycle.
  p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_q |=> !strobe_q);

  // R7: the recovered bit holds between strobes.
  p_bit_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_q |-> $stable(bit_q));

endmodule

// File: rtl/nrz_bit_timing.sv
`timescale 1ns/1ps
module nrz_bit_timing
  import nbt_pkg::*;
#(
  parameter int unsigned OVERSAMPLE  = NBT_OVERSAMPLE,
  parameter int unsigned CNT_W       = NBT_CNT_W,
  parameter int unsigned SYNC_STAGES = NBT_SYNC_STAGES
) (
  input  logic clk_fast,
  input  logic rst_n,
  input  logic line_in,
  output logic strobe_o,
  output logic bit_o,
  output logic edge_o
);

  localparam int unsigned MID_PHASE = nbt_mid_phase(OVERSAMPLE);

  logic rst_sync_n;
  logic smp;
  logic realign;

  // Reset asserts asynchronously and releases on a clock edge.
  nbt_sync_chain #(.STAGES(2)) u_rst_sync (
    .clk   (clk_fast),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  nbt_sync_chain #(.STAGES(SYNC_STAGES)) u_line_sync (
    .clk   (clk_fast),
    .rst_n (rst_sync_n),
    .d     (line_in),
    .q     (smp)
  );

  nbt_edge_detect u_edge (
    .clk    (clk_fast),
    .rst_n  (rst_sync_n),
    .smp    (smp),
    .edge_o (realign)
  );

  nbt_phase_timer #(
    .OVERSAMPLE (OVERSAMPLE),
    .CNT_W      (CNT_W),
    .MID_PHASE  (MID_PHASE)
  ) u_timer (
    .clk      (clk_fast),
    .rst_n    (rst_sync_n),
    .realign  (realign),
    .smp      (smp),
    .strobe_o (strobe_o),
    .bit_o    (bit_o)
  );

  assign edge_o = realign;

  // R1: while reset is applied no output is active.
  p_reset_quiet_r1: assert property (@(posedge clk_fast)
    !rst_sync_n |-> (!strobe_o && !edge_o && !bit_o));

endmodule

// File: tb/nrz_bit_timing_bench.sv
`timescale 1ns/1ps
module nrz_bit_timing_bench;

  logic clk = 1'b0;
  logic rst_n;
  logic line_in;
  logic strobe_o, bit_o, edge_o;

  always #10 clk = ~clk;

  nrz_bit_timing u_nrz_bit_timing (
    .clk_fast (clk),
    .rst_n    (rst_n),
    .line_in  (line_in),
    .strobe_o (strobe_o),
    .bit_o    (bit_o),
    .edge_o   (edge_o)
  );

  // Stimulus vectors: {bit period in clocks, bit count, pattern sent LSB first}.
  localparam int NVEC = 6;
  localparam logic [36:0] VEC [NVEC] = '{
    {5'd16, 8'd24, 24'h555555},
    {5'd16, 8'd24, 24'hF000FF},
    {5'd15, 8'd24, 24'h555555},
    {5'd17, 8'd24, 24'h555555},
    {5'd15, 8'd24, 24'h6DB6DB},
    {5'd17, 8'd24, 24'hE38E39}
  };

  int   nchk  = 0;
  int   nfail = 0;
  int   cyc   = 0;
  logic hist [0:7];
  bit   watch = 1'b0;
  int   win_lo, win_hi;
  int   win_strobes, data_bad;
  bit   done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Observe outputs at the falling edge, then drive the next line level.
  task automatic tick(input logic lvl);
    @(negedge clk);
    cyc++;
    if (watch && strobe_o && cyc >= win_lo && cyc < win_hi) begin
      win_strobes++;
      if (bit_o !== hist[(cyc - 3) % 8]) data_bad++;
    end
    line_in = lvl;
    hist[cyc % 8] = lvl;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) tick(1'b0);
    rst_n = 1'b1;
    repeat (24) tick(1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int t_first, t_second, t_third, n_seen;
    int e_at, s_at, n_edges;
    bit e_wide, s_after;
    logic [36:0] v;
    int per, nb;

    rst_n   = 1'b0;
    line_in = 1'b0;
    for (int i = 0; i < 8; i++) hist[i] = 1'b0;

    // R1: reset state.
    repeat (4) tick(1'b0);
    check(strobe_o === 1'b0, "R1 strobe in reset", int'(strobe_o), 0);
    check(bit_o === 1'b0,    "R1 bit in reset",    int'(bit_o),    0);
    check(edge_o === 1'b0,   "R1 edge in reset",   int'(edge_o),   0);
    rst_n = 1'b1;
    repeat (24) tick(1'b0);

    // R5: free-running strobe spacing with an idle line.
    t_first = -1; t_second = -1; t_third = -1; n_seen = 0;
    for (int i = 0; i < 60; i++) begin
      tick(1'b0);
      if (strobe_o) begin
        if (n_seen == 0) t_first = cyc;
        else if (n_seen == 1) t_second = cyc;
        else if (n_seen == 2) t_third = cyc;
        n_seen++;
      end
    end
    check(t_second - t_first == 16, "R5 free-run spacing 1", t_second - t_first, 16);
    check(t_third - t_second == 16, "R5 free-run spacing 2", t_third - t_second, 16);

    // R2, R4, R6, R7: a single rising change after idle.
    e_at = -1; s_at = -1; e_wide = 1'b0; s_after = 1'b0;
    begin
      int k0;
      k0 = cyc + 1;
      for (int i = 0; i < 30; i++) begin
        tick(1'b1);
        if (edge_o && e_at < 0) e_at = cyc;
        else if (edge_o && cyc == e_at + 1) e_wide = 1'b1;
        if (s_at >= 0 && cyc == s_at + 1) s_after = strobe_o;
        if (e_at >= 0 && cyc > e_at + 1 && strobe_o && s_at < 0) begin
          s_at = cyc;
          check(bit_o === 1'b1, "R7 bit after edge", int'(bit_o), 1);
        end
      end
      check(e_at - k0 == 3, "R2 edge latency", e_at - k0, 3);
      check(!e_wide, "R2 edge width", int'(e_wide), 0);
      check(s_at - e_at == 9, "R4 edge to strobe", s_at - e_at, 9);
      check(!s_after, "R6 strobe width", int'(s_after), 0);
    end

    // R7: async reset with bit_o high clears it immediately (R1).
    @(negedge clk);
    check(bit_o === 1'b1, "R7 bit held high", int'(bit_o), 1);
    #3 rst_n = 1'b0;
    #1 check(bit_o === 1'b0 && strobe_o === 1'b0, "R1 async clear", int'(bit_o), 0);
    repeat (2) tick(1'b1);
    rst_n = 1'b1;
    line_in = 1'b0;

    // R3: one-sample and two-sample pulses.
    do_reset();
    n_edges = 0;
    tick(1'b1);
    for (int i = 0; i < 12; i++) begin
      tick(1'b0);
      if (edge_o) n_edges++;
    end
    check(n_edges == 1, "R3 one-sample pulse", n_edges, 1);
    repeat (10) tick(1'b0);
    n_edges = 0;
    tick(1'b1);
    tick(1'b1);
    for (int i = 0; i < 12; i++) begin
      tick(1'b0);
      if (edge_o) n_edges++;
    end
    check(n_edges == 2, "R3 two-sample pulse", n_edges, 2);

    // R8, R7: stream vectors across the rate range.
    for (int vi = 0; vi < NVEC; vi++) begin
      v   = VEC[vi];
      per = int'(v[36:32]);
      nb  = int'(v[31:24]);
      do_reset();
      win_lo = cyc + 1 + 12;
      win_hi = cyc + 1 + nb * per + 12;
      win_strobes = 0;
      data_bad = 0;
      watch = 1'b1;
      for (int b = 0; b < nb; b++)
        for (int p = 0; p < per; p++) tick(v[b]);
      for (int i = 0; i < 24; i++) tick(~v[nb-1]);
      watch = 1'b0;
      check(win_strobes == nb, "R8 one strobe per bit", win_strobes, nb);
      check(data_bad == 0, "R7 recovered bits", data_bad, 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule